// File: doc/BRIEF.md
# Serial Byte Viewer with Nibble-Swap Button

This block listens to one asynchronous serial receive line, recovers 8-bit characters from it and drives the bit pattern of the most recent good character onto eight LED outputs. A push-button input changes the view: while it is held, the two 4-bit halves of the shown byte trade places, and on release the plain order comes back.

All three external inputs arrive unsynchronized. The reset pin, the button pin and the serial pin each pass through a two-flop synchronizer. The synchronized reset asserts asynchronously and releases on a clock edge. A divider makes a one-cycle enable at 16 times the baud rate. A receive state machine uses that enable to confirm the start bit, sample the data bits near their centres and check the stop bit. A good frame produces a one-cycle valid pulse that loads the display register. A frame with a bad stop bit is dropped.

Top module: `serial_led_viewer`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `led_o` reads 0x00.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with the line idle high. A frame at 115200 baud, with a 100 MHz clock, puts its data byte on `led_o` before the stop bit ends.
- R3: When several good frames arrive, `led_o` shows the byte of the latest one.
- R4: With `btn_i` high, `led_o` shows `{byte[3:0], byte[7:4]}` of the held byte within four clocks. With `btn_i` low it shows `byte[7:0]` again within four clocks.
- R5: A frame whose stop bit samples low changes nothing. `led_o` keeps its previous value, and the next good frame is still received.
- R6: A low pulse on the line shorter than half a bit is not taken as a start bit. `led_o` is unchanged and the next frame is received correctly.
- R7: The sampling enable is a single-cycle pulse that repeats every floor(CLOCK_RATE / (BAUD_RATE * 16)) clocks, which is 54 clocks by default. Frames at the nominal rate are decoded bit-exactly.
- R8: A byte that arrives while `btn_i` is held is shown swapped at once. After release the same byte is shown unswapped.
- R9: Pulling `rst_ni` low clears `led_o` to 0x00 with no clock edge needed. After release, reception works again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (CLOCK_RATE Hz) |
| rst_ni | input | 1 | Asynchronous active-low reset pin |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| btn_i | input | 1 | Push-button, high selects the nibble-swapped view |
| led_o | output | DATA_W | LED drive showing the last good byte |

## Verification
The display register has two sources that can act in the same cycle: the valid pulse that loads a new byte, and the synchronized button that selects the swapped view. To make them coincide, the bench holds the button through an entire frame, so the byte load happens while the swap selection is active. The check passes only if the display shows the swapped form of the new byte, not a swapped old byte or an unswapped new byte, and shows the plain new byte after release. Assertions also cover the cycles around every button edge and require that the display swaps exactly when no load is in flight.

// File: rtl/slr_pkg.sv
package slr_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned w;
    w = $clog2(v);
    return (w == 0) ? 1 : w;
  endfunction

endpackage

// File: rtl/slr_sync2.sv
module slr_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/slr_baud_tick.sv
module slr_baud_tick
  import slr_pkg::*;
#(
  parameter int unsigned CLOCK_RATE = 100_000_000,
  parameter int unsigned BAUD_RATE  = 115_200,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned DIV = CLOCK_RATE / (BAUD_RATE * OVERSAMPLE);
  localparam int unsigned CW  = clog2_min1(DIV);
  localparam logic [CW-1:0] TC = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_tc;

  assign at_tc = (cnt_q == TC);

  always_comb begin
    if (at_tc) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = at_tc;

  // Checker: separate gap counter between enables
  logic [CW:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (tick_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q <= (CW+1)'(DIV)) begin
        gap_q <= gap_q + (CW+1)'(1);
      end
    end
  end

  a_r7_tick_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |-> (gap_q == (CW+1)'(DIV - 1)))
    else $error("R7 sampling enable period wrong");

  a_r7_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (DIV > 1)) |=> !tick_o)
    else $error("R7 sampling enable longer than one cycle");

endmodule

// File: rtl/slr_rx_fsm.sv
module slr_rx_fsm
  import slr_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam int unsigned TW = clog2_min1(OVERSAMPLE);
  localparam int unsigned BW = clog2_min1(DATA_W);
  localparam logic [TW-1:0] T_MID  = TW'(OVERSAMPLE / 2 - 1);
  localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [TW-1:0]     tcnt_q, tcnt_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              valid_q, valid_d;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    shift_d = shift_q;
    valid_d = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (tick_i && !rx_i) begin
          state_d = RX_START;
          tcnt_d  = '0;
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (tcnt_q == T_MID) begin
            tcnt_d = '0;
            bcnt_d = '0;
            state_d = rx_i ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_d = tcnt_q + TW'(1);
          end
        end
      end
      RX_DATA: begin
        if (tick_i) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d  = '0;
            shift_d = {rx_i, shift_q[DATA_W-1:1]};
            if (bcnt_q == B_LAST) state_d = RX_STOP;
            else                  bcnt_d  = bcnt_q + BW'(1);
          end else begin
            tcnt_d = tcnt_q + TW'(1);
          end
        end
      end
      RX_STOP: begin
        if (tick_i) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d  = '0;
            valid_d = rx_i;
            state_d = RX_IDLE;
          end else begin
            tcnt_d = tcnt_q + TW'(1);
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      shift_q <= shift_d;
      valid_q <= valid_d;
    end
  end

  assign data_o  = shift_q;
  assign valid_o = valid_q;

  a_r2_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q)
    else $error("R2 valid pulse longer than one cycle");

  a_r5_valid_needs_high_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ($past(rx_i) && ($past(state_q) == RX_STOP)))
    else $error("R5 byte accepted without a high stop bit");

endmodule

// File: rtl/slr_led_view.sv
module slr_led_view #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              swap_i,
  output logic [DATA_W-1:0] led_o
);

  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] byte_q, byte_d;
  logic [DATA_W-1:0] led_q, led_d;
  logic [DATA_W-1:0] swapped;

  always_comb begin
    byte_d  = valid_i ? data_i : byte_q;
    swapped = {byte_d[HALF-1:0], byte_d[DATA_W-1:HALF]};
    led_d   = swap_i ? swapped : byte_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      led_q  <= '0;
    end else begin
      byte_q <= byte_d;
      led_q  <= led_d;
    end
  end

  assign led_o = led_q;

  a_r4_swap_on_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((swap_i != $past(swap_i)) && !valid_i && !$past(valid_i))
      |=> (led_q == {$past(led_q[HALF-1:0]), $past(led_q[DATA_W-1:HALF])}))
    else $error("R4 display did not swap halves on button change");

  a_r5_hold_without_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !$past(valid_i) && (swap_i == $past(swap_i))) |=> $stable(led_q))
    else $error("R5 display changed without a valid byte");

endmodule

// File: rtl/serial_led_viewer.sv
module serial_led_viewer #(
  parameter int unsigned CLOCK_RATE = 100_000_000,
  parameter int unsigned BAUD_RATE  = 115_200,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              btn_i,
  output logic [DATA_W-1:0] led_o
);

  localparam int unsigned NSYNC = 2;
  localparam logic [NSYNC-1:0] SYNC_RST = 2'b01;

  logic              rst_sync_n;
  logic [NSYNC-1:0]  raw_in, sync_out;
  logic              tick;
  logic [DATA_W-1:0] rx_data;
  logic              rx_valid;

  slr_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  assign raw_in = {btn_i, rxd_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_in_sync
    slr_sync2 #(.RST_VAL(SYNC_RST[g])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .d_i   (raw_in[g]),
      .q_o   (sync_out[g])
    );
  end

  slr_baud_tick #(
    .CLOCK_RATE(CLOCK_RATE),
    .BAUD_RATE (BAUD_RATE),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .tick_o(tick)
  );

  slr_rx_fsm #(
    .DATA_W    (DATA_W),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_i (tick),
    .rx_i   (sync_out[0]),
    .data_o (rx_data),
    .valid_o(rx_valid)
  );

  slr_led_view #(.DATA_W(DATA_W)) u_view (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .valid_i(rx_valid),
    .data_i (rx_data),
    .swap_i (sync_out[1]),
    .led_o  (led_o)
  );

endmodule

// File: tb/tb_serial_led_viewer.sv
module tb_serial_led_viewer;

  localparam int BIT_CYC = (100_000_000 / (115_200 * 16)) * 16;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       rxd;
  logic       btn;
  logic [7:0] led;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  serial_led_viewer dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .rxd_i (rxd),
    .btn_i (btn),
    .led_o (led)
  );

  always #5 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (led !== exp) begin
      n_bad++;
      $display("FAIL %s: led=%h expected %h", req, led, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit good_stop);
    rxd = 1'b0;
    cyc(BIT_CYC);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      cyc(BIT_CYC);
    end
    if (good_stop) begin
      rxd = 1'b1;
      cyc(BIT_CYC);
    end else begin
      rxd = 1'b0;
      cyc(600);
      rxd = 1'b1;
      cyc(BIT_CYC * 2);
    end
    cyc(20);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; rxd = 1'b1; btn = 1'b0;
    cyc(5);
    check("R1 during reset", 8'h00);
    rst_ni = 1'b1;
    cyc(10);
    check("R1 after release", 8'h00);
  endtask

  task automatic t_basic;
    send_frame(8'h41, 1'b1);
    check("R2 byte 0x41", 8'h41);
    send_frame(8'hFF, 1'b1);
    check("R2 byte 0xFF", 8'hFF);
    send_frame(8'hA5, 1'b1);
    check("R7 alternating byte at nominal rate", 8'hA5);
  endtask

  task automatic t_latest;
    send_frame(8'h3C, 1'b1);
    check("R3 first of pair", 8'h3C);
    send_frame(8'hC3, 1'b1);
    check("R3 latest byte", 8'hC3);
  endtask

  task automatic t_button;
    btn = 1'b1;
    cyc(4);
    check("R4 swapped view", 8'h3C);
    btn = 1'b0;
    cyc(4);
    check("R4 normal view", 8'hC3);
  endtask

  task automatic t_bad_stop;
    send_frame(8'h7E, 1'b0);
    cyc(1000);
    check("R5 bad stop discarded", 8'hC3);
    send_frame(8'h5A, 1'b1);
    check("R5 recovery frame", 8'h5A);
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    cyc(200);
    rxd = 1'b1;
    cyc(2000);
    check("R6 glitch ignored", 8'h5A);
    send_frame(8'h81, 1'b1);
    check("R6 frame after glitch", 8'h81);
  endtask

  task automatic t_button_during_frame;
    btn = 1'b1;
    cyc(10);
    check("R8 old byte swapped before frame", 8'h18);
    send_frame(8'h12, 1'b1);
    check("R8 new byte swapped on arrival", 8'h21);
    btn = 1'b0;
    cyc(4);
    check("R8 new byte plain after release", 8'h12);
  endtask

  task automatic t_mid_reset;
    rst_ni = 1'b0;
    #2;
    check("R9 async clear", 8'h00);
    cyc(3);
    rst_ni = 1'b1;
    cyc(10);
    send_frame(8'h96, 1'b1);
    check("R9 reception after reset", 8'h96);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_latest();
    t_button();
    t_bad_stop();
    t_glitch();
    t_button_during_frame();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule